// File: doc/BRIEF.md
# Oscillator Stabilization Wait Controller

This block holds back the clock-ready indication for two oscillators after a startup or wake-up event. The fast (main) oscillator and the slow (sub) oscillator each have their own wait timer. A timer advances on a one-cycle tick strobe that marks one period of its oscillator. Both timers run in the single `clk` domain of the block. The main wait length is chosen by a 2-bit length code. The sub wait has a fixed length: a prescaler of `SUB_EXP` bits counts up from zero, and the wait ends when it wraps around.

Three things decide whether a wait is inserted: the kind of event, the operating mode in force when it arrives, and the build parameter `HAS_POR`, which says whether the chip has a power-on reset circuit. When no wait is required, the ready flag is set on the first clock edge after the event. Every reset event clears any wait in progress and returns the length code to its build-time value `SEL_INIT`. A busy flag shows that at least one wait is running.

Top module: `osw_ctrl`

## Requirements
- R1: While `rst_n` is low and afterwards until the first event, `main_rdy`, `sub_rdy` and `busy` are 0. Ticks alone never raise a ready flag.
- R2: A reset event of cause power-on (`rst_cause`=0) starts a sub wait. `sub_rdy` goes low and rises on the clock edge that samples the 2^`SUB_EXP`-th `sub_tick` after the event. Edges without a tick do not advance the wait.
- R3: With `HAS_POR`=1, a reset event starts a main wait in three cases: cause power-on in any mode; cause external (1) in sub mode (`cur_mode`=1); cause external in either stop mode (`cur_mode`=2 main-stop, 3 sub-stop). No other reset event starts a main wait.
- R4: With `HAS_POR`=0, a reset event starts a main wait only for cause software (2) or watchdog (3) in sub mode.
- R5: A reset event that needs no wait for a clock sets that clock's ready flag on the first clock edge after the event.
- R6: `ext_wake` in sub-stop mode starts a sub wait. In any other mode it leaves both ready flags unchanged.
- R7: `clk_sel_req` in sub mode starts a main wait that uses the current length code. In other modes it has no effect.
- R8: Length code c selects a main wait of 2^`MAIN_EXP[c]` main ticks (defaults 2^2, 2^12, 2^13, 2^14 for c = 0..3). `sel_wr` loads `sel_wdata` into the code. A reset event returns the code to `SEL_INIT`, and that reset's own wait uses `SEL_INIT`.
- R9: A new qualifying event during a wait restarts that wait from zero.
- R10: A reset event cancels any wait in progress. A clock whose wait is not restarted by that event becomes ready on the next edge.
- R11: `busy` is 1 exactly while a main or sub wait is in progress.
- R12: A reset event takes priority over `ext_wake` and `clk_sel_req` arriving in the same cycle. Those two are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| rst_event | input | 1 | One-cycle strobe: a chip reset occurred |
| rst_cause | input | 2 | Reset kind: 0 power-on, 1 external, 2 software, 3 watchdog |
| cur_mode | input | 2 | Mode in force: 0 main, 1 sub, 2 main-stop, 3 sub-stop |
| ext_wake | input | 1 | One-cycle strobe: external interrupt wake |
| clk_sel_req | input | 1 | One-cycle strobe: request to switch from sub to main clock |
| sel_wr | input | 1 | Load strobe for the main wait length code |
| sel_wdata | input | 2 | New main wait length code |
| main_tick | input | 1 | One main oscillator period elapsed |
| sub_tick | input | 1 | One sub oscillator period elapsed |
| main_rdy | output | 1 | Main clock may be used |
| sub_rdy | output | 1 | Sub clock may be used |
| busy | output | 1 | A stabilization wait is running |

## Verification
The bound checker watches several rules on every cycle. An external reset in main mode always releases the main clock on the next edge. A power-on reset, a sub-stop wake, and a clock switch request in sub mode each drop the matching ready flag and raise `busy` on the next edge. A ready flag rises only after a tick or a reset event. `busy` is never high while both clocks are ready.

The bench covers what needs an exact count of cycles or a reference table. It sweeps every reset cause against every mode for both `HAS_POR` builds. It measures each wait length to the cycle for every length code. It also exercises restart, cancellation, tick gating, same-cycle priority, and the return of the length code to `SEL_INIT`.

// File: rtl/osw_pkg.sv
package osw_pkg;
    typedef enum logic [1:0] {
        CAUSE_POR = 2'd0,
        CAUSE_EXT = 2'd1,
        CAUSE_SW  = 2'd2,
        CAUSE_WDT = 2'd3
    } osw_cause_e;

    typedef enum logic [1:0] {
        MODE_MAIN  = 2'd0,
        MODE_SUB   = 2'd1,
        MODE_MSTOP = 2'd2,
        MODE_SSTOP = 2'd3
    } osw_mode_e;
endpackage

// File: rtl/osw_qualify.sv
module osw_qualify
    import osw_pkg::*;
#(
    parameter bit HAS_POR = 1'b1
) (
    input  logic       rst_event,
    input  logic [1:0] rst_cause,
    input  logic [1:0] cur_mode,
    input  logic       ext_wake,
    input  logic       clk_sel_req,
    output logic       main_start,
    output logic       main_rel,
    output logic       sub_start,
    output logic       sub_rel
);
    osw_cause_e cause;
    osw_mode_e  mode;
    logic       in_stop;
    logic       main_on_rst;

    assign cause   = osw_cause_e'(rst_cause);
    assign mode    = osw_mode_e'(cur_mode);
    assign in_stop = (mode == MODE_MSTOP) || (mode == MODE_SSTOP);

    // Which reset events require the main oscillator to settle
    generate
        if (HAS_POR) begin : g_por
            assign main_on_rst = (cause == CAUSE_POR)
                              || ((cause == CAUSE_EXT) && ((mode == MODE_SUB) || in_stop));
        end else begin : g_nopor
            assign main_on_rst = ((cause == CAUSE_SW) || (cause == CAUSE_WDT))
                              && (mode == MODE_SUB);
        end
    endgenerate

    always_comb begin
        main_start = 1'b0;
        main_rel   = 1'b0;
        sub_start  = 1'b0;
        sub_rel    = 1'b0;
        if (rst_event) begin
            main_start = main_on_rst;
            main_rel   = !main_on_rst;
            sub_start  = (cause == CAUSE_POR);
            sub_rel    = (cause != CAUSE_POR);
        end else begin
            main_start = clk_sel_req && (mode == MODE_SUB);
            sub_start  = ext_wake && (mode == MODE_SSTOP);
        end
    end
endmodule

// File: rtl/osw_wait_timer.sv
module osw_wait_timer #(
    parameter int unsigned CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rel,
    input  logic          tick,
    input  logic [CW-1:0] term,
    output logic          rdy,
    output logic          waiting
);
    typedef struct packed {
        logic          waiting;
        logic          rdy;
        logic [CW-1:0] cnt;
        logic [CW-1:0] term;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.waiting = 1'b1;
            s_d.rdy     = 1'b0;
            s_d.cnt     = '0;
            s_d.term    = term;
        end else if (rel) begin
            s_d.waiting = 1'b0;
            s_d.rdy     = 1'b1;
            s_d.cnt     = '0;
        end else if (s_q.waiting && tick) begin
            if (s_q.cnt == s_q.term) begin
                s_d.waiting = 1'b0;
                s_d.rdy     = 1'b1;
                s_d.cnt     = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdy     = s_q.rdy;
    assign waiting = s_q.waiting;
endmodule

// File: rtl/osw_ctrl.sv
module osw_ctrl
    import osw_pkg::*;
#(
    parameter bit          HAS_POR     = 1'b1,
    parameter int unsigned SEL_INIT    = 3,
    parameter int unsigned SUB_EXP     = 15,
    parameter int unsigned MAIN_EXP[4] = '{2, 12, 13, 14}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_event,
    input  logic [1:0] rst_cause,
    input  logic [1:0] cur_mode,
    input  logic       ext_wake,
    input  logic       clk_sel_req,
    input  logic       sel_wr,
    input  logic [1:0] sel_wdata,
    input  logic       main_tick,
    input  logic       sub_tick,
    output logic       main_rdy,
    output logic       sub_rdy,
    output logic       busy
);
    function automatic int unsigned widest();
        int unsigned m = 1;
        for (int i = 0; i < 4; i++) if (MAIN_EXP[i] > m) m = MAIN_EXP[i];
        return m;
    endfunction

    localparam int unsigned MCW = widest();
    localparam logic [1:0]  SEL_RST = 2'(SEL_INIT);

    typedef struct packed {
        logic [1:0] sel;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             main_start, main_rel, sub_start, sub_rel;
    logic             main_wait, sub_wait;
    logic [1:0]       sel_eff;
    logic [MCW:0]     main_pow;
    logic [MCW-1:0]   main_term;
    logic [SUB_EXP-1:0] sub_term;

    always_comb begin
        c_d = c_q;
        if (rst_event)   c_d.sel = SEL_RST;
        else if (sel_wr) c_d.sel = sel_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q.sel <= SEL_RST;
        else        c_q     <= c_d;
    end

    // A reset event measures its wait with the build-time code
    always_comb begin
        sel_eff   = rst_event ? SEL_RST : c_q.sel;
        main_pow  = (MCW+1)'(1) << MAIN_EXP[sel_eff];
        main_term = MCW'(main_pow - (MCW+1)'(1));
        sub_term  = '1;
    end

    osw_qualify #(.HAS_POR(HAS_POR)) u_qual (
        .rst_event   (rst_event),
        .rst_cause   (rst_cause),
        .cur_mode    (cur_mode),
        .ext_wake    (ext_wake),
        .clk_sel_req (clk_sel_req),
        .main_start  (main_start),
        .main_rel    (main_rel),
        .sub_start   (sub_start),
        .sub_rel     (sub_rel)
    );

    osw_wait_timer #(.CW(MCW)) u_main_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (main_start),
        .rel     (main_rel),
        .tick    (main_tick),
        .term    (main_term),
        .rdy     (main_rdy),
        .waiting (main_wait)
    );

    osw_wait_timer #(.CW(SUB_EXP)) u_sub_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sub_start),
        .rel     (sub_rel),
        .tick    (sub_tick),
        .term    (sub_term),
        .rdy     (sub_rdy),
        .waiting (sub_wait)
    );

    assign busy = main_wait | sub_wait;
endmodule

module osw_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_event,
    input logic [1:0] rst_cause,
    input logic [1:0] cur_mode,
    input logic       ext_wake,
    input logic       clk_sel_req,
    input logic       main_tick,
    input logic       sub_tick,
    input logic       main_rdy,
    input logic       sub_rdy,
    input logic       busy
);
    a_r5_ext_main_release: assert property (@(posedge clk) disable iff (!rst_n)
        rst_event && rst_cause == 2'd1 && cur_mode == 2'd0 |=> main_rdy);

    a_r2_por_sub_wait: assert property (@(posedge clk) disable iff (!rst_n)
        rst_event && rst_cause == 2'd0 |=> !sub_rdy && busy);

    a_r6_wake_sub_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_event && ext_wake && cur_mode == 2'd3 |=> !sub_rdy && busy);

    a_r7_switch_main_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_event && clk_sel_req && cur_mode == 2'd1 |=> !main_rdy && busy);

    a_r2_sub_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_rdy) |-> $past(sub_tick) || $past(rst_event));

    a_r8_main_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_rdy) |-> $past(main_tick) || $past(rst_event));

    a_r11_idle_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        main_rdy && sub_rdy |-> !busy);
endmodule

bind osw_ctrl osw_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_event   (rst_event),
    .rst_cause   (rst_cause),
    .cur_mode    (cur_mode),
    .ext_wake    (ext_wake),
    .clk_sel_req (clk_sel_req),
    .main_tick   (main_tick),
    .sub_tick    (sub_tick),
    .main_rdy    (main_rdy),
    .sub_rdy     (sub_rdy),
    .busy        (busy)
);

// File: tb/osw_ctrl_tb_top.sv
`timescale 1ns/1ps
module osw_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_event = 1'b0;
    logic [1:0] rst_cause = '0;
    logic [1:0] cur_mode = '0;
    logic       ext_wake = 1'b0;
    logic       clk_sel_req = 1'b0;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_wdata = '0;
    logic       main_tick = 1'b1;
    logic       sub_tick = 1'b1;
    logic       m1, s1, b1, m0, s0, b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cur_sel = 2;
    localparam int SUB_LEN = 16;

    always #4 clk = ~clk;

    osw_ctrl #(.HAS_POR(1'b1), .SEL_INIT(2), .SUB_EXP(4), .MAIN_EXP('{1, 2, 3, 4})) dut_i (
        .clk(clk), .rst_n(rst_n), .rst_event(rst_event), .rst_cause(rst_cause),
        .cur_mode(cur_mode), .ext_wake(ext_wake), .clk_sel_req(clk_sel_req),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .main_tick(main_tick), .sub_tick(sub_tick),
        .main_rdy(m1), .sub_rdy(s1), .busy(b1));

    osw_ctrl #(.HAS_POR(1'b0), .SEL_INIT(2), .SUB_EXP(4), .MAIN_EXP('{1, 2, 3, 4})) dut_np_i (
        .clk(clk), .rst_n(rst_n), .rst_event(rst_event), .rst_cause(rst_cause),
        .cur_mode(cur_mode), .ext_wake(ext_wake), .clk_sel_req(clk_sel_req),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .main_tick(main_tick), .sub_tick(sub_tick),
        .main_rdy(m0), .sub_rdy(s0), .busy(b0));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int main_len(input int sel);
        return 1 << (sel + 1);
    endfunction

    function automatic int exp_main(input bit por, input int cause, input int mode,
                                    input bit rst, input bit csel);
        bit q;
        if (rst) begin
            if (por) q = (cause == 0) || (cause == 1 && mode != 0);
            else     q = (cause == 2 || cause == 3) && mode == 1;
            return q ? main_len(2) : 1;
        end
        if (csel && mode == 1) return main_len(cur_sel);
        return 1;
    endfunction

    function automatic int exp_sub(input int cause, input int mode, input bit rst, input bit wake);
        if (rst) return (cause == 0) ? SUB_LEN : 1;
        return (wake && mode == 3) ? SUB_LEN : 1;
    endfunction

    task automatic fire(input int cause, input int mode, input bit rst, input bit wake, input bit csel);
        @(negedge clk);
        rst_cause   = 2'(cause);
        cur_mode    = 2'(mode);
        rst_event   = rst;
        ext_wake    = wake;
        clk_sel_req = csel;
        @(negedge clk);
        rst_event   = 1'b0;
        ext_wake    = 1'b0;
        clk_sel_req = 1'b0;
    endtask

    task automatic observe(input string req, input int em1, input int es1, input int em0, input int es0);
        int f[4] = '{0, 0, 0, 0};
        int bb1 = 0;
        int bb0 = 0;
        for (int n = 1; n <= 64; n++) begin
            @(posedge clk); #1;
            if (n == 1) begin bb1 = b1; bb0 = b0; end
            if (m1 && f[0] == 0) f[0] = n;
            if (s1 && f[1] == 0) f[1] = n;
            if (m0 && f[2] == 0) f[2] = n;
            if (s0 && f[3] == 0) f[3] = n;
            if (f[0] != 0 && f[1] != 0 && f[2] != 0 && f[3] != 0) break;
        end
        chk(req, "por main ready cycle", f[0], em1);
        chk(req, "por sub ready cycle", f[1], es1);
        chk(req, "nopor main ready cycle", f[2], em0);
        chk(req, "nopor sub ready cycle", f[3], es0);
        chk({req, " R11"}, "por busy", bb1, int'(em1 > 1 || es1 > 1));
        chk({req, " R11"}, "nopor busy", bb0, int'(em0 > 1 || es0 > 1));
        chk({req, " R11"}, "por busy at end", int'(b1), 0);
    endtask

    task automatic event_check(input string req, input int cause, input int mode,
                               input bit rst, input bit wake, input bit csel);
        int em1 = exp_main(1'b1, cause, mode, rst, csel);
        int em0 = exp_main(1'b0, cause, mode, rst, csel);
        int es  = exp_sub(cause, mode, rst, wake);
        fire(cause, mode, rst, wake, csel);
        if (rst) cur_sel = 2;
        observe(req, em1, es, em0, es);
    endtask

    task automatic write_sel(input int v);
        @(negedge clk);
        sel_wr = 1'b1;
        sel_wdata = 2'(v);
        @(negedge clk);
        sel_wr = 1'b0;
        cur_sel = v;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state, ticks alone raise nothing
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "main_rdy in reset", int'(m1), 0);
        chk("R1", "sub_rdy in reset", int'(s1), 0);
        chk("R1", "busy in reset", int'(b1 | b0), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (40) @(posedge clk);
        #1;
        chk("R1", "ready after ticks only", int'(m1 | s1 | m0 | s0), 0);
        chk("R1", "busy after ticks only", int'(b1 | b0), 0);

        // R2: power-on from main mode
        event_check("R2", 0, 0, 1'b1, 1'b0, 1'b0);

        // R3 R4 R5: every cause against every mode
        for (int c = 0; c < 4; c++)
            for (int md = 0; md < 4; md++)
                event_check("R3 R4 R5", c, md, 1'b1, 1'b0, 1'b0);

        // R6: wake in every mode
        for (int md = 0; md < 4; md++)
            event_check("R6", 1, md, 1'b0, 1'b1, 1'b0);

        // R7 R8: clock switch request for each code and mode
        for (int s = 0; s < 4; s++) begin
            write_sel(s);
            for (int md = 0; md < 4; md++)
                event_check("R7 R8", 0, md, 1'b0, 1'b0, 1'b1);
        end

        // R8: code 3 written, reset must use the build-time code
        write_sel(3);
        event_check("R8", 1, 1, 1'b1, 1'b0, 1'b0);
        event_check("R8", 0, 1, 1'b0, 1'b0, 1'b1);

        // R12: reset with wake and switch in the same cycle
        event_check("R12", 1, 3, 1'b1, 1'b1, 1'b1);
        event_check("R12", 2, 1, 1'b1, 1'b1, 1'b1);

        // R9: second power-on restarts both waits
        fire(0, 0, 1'b1, 1'b0, 1'b0);
        repeat (5) @(posedge clk);
        fire(0, 0, 1'b1, 1'b0, 1'b0);
        observe("R9", main_len(2), SUB_LEN, 1, SUB_LEN);

        // R10: external reset cancels pending waits
        fire(0, 0, 1'b1, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        fire(1, 0, 1'b1, 1'b0, 1'b0);
        observe("R10", 1, 1, 1, 1);

        // R2: sub wait frozen without ticks
        sub_tick = 1'b0;
        fire(0, 0, 1'b1, 1'b0, 1'b0);
        repeat (30) @(posedge clk);
        #1;
        chk("R2", "sub_rdy without ticks", int'(s1), 0);
        chk("R2 R11", "busy without ticks", int'(b1), 1);
        sub_tick = 1'b1;
        observe("R2", 1, SUB_LEN, 1, SUB_LEN);

        summary();
        $finish;
    end
endmodule